// File: doc/BRIEF.md
# Word Message Network Interface

This block couples a processor execute stage to an on-chip router so that the core can exchange single-word messages with other nodes. Two first-in first-out queues decouple the two sides. The outbound queue collects messages from the core, and each message pairs a destination node id with a 64-bit word. The inbound queue collects words from the router, and each word is tagged with the id of the node that sent it. Messages leave toward the router in the order the core wrote them, so longer data can travel as a sequence of words.

The core issues at most one operation per cycle. A send places a node id and a word into the outbound queue. A peek returns the sender id of the oldest inbound message and leaves that message in place. A read returns the oldest inbound word and removes it. Four status outputs feed the branch unit directly, so software can test for space or for arrivals before it acts. No operation ever stalls. An operation the queues cannot serve changes nothing and raises a one-cycle exception flag.

On the router side, each direction uses a plain valid/ready stream.

Top module: `msg_nif`

## Requirements
- R1: After reset both queues are empty: `tx_valid_o`=0, `rx_ready_o`=1, `br_none_rx_o`=1, `br_can_send_o`=1, and `exc_o`=0.
- R2: A send (`op_i`=1) with space in the outbound queue enqueues {`op_node_i`, `op_data_i`}. While the queue holds data, `tx_valid_o`=1 and `tx_node_o`/`tx_data_o` show the oldest entry. That entry leaves on a cycle with `tx_ready_i`=1. Entries leave in the order they were sent.
- R3: The outbound queue holds 8 entries. `br_can_send_o` is 1 exactly when fewer than 8 are held, and `br_send_blocked_o` is its inverse.
- R4: A send issued while 8 entries are held enqueues nothing. `exc_o` is 1 in the following cycle.
- R5: A peek (`op_i`=2) on a non-empty inbound queue drives `res_data_o` with the head sender id, zero-extended, in the same cycle. It removes nothing.
- R6: A read (`op_i`=3) on a non-empty inbound queue drives `res_data_o` with the head word in the same cycle. The entry is removed at the clock edge.
- R7: A peek or read issued while the inbound queue is empty removes nothing and drives `res_data_o`=0. `exc_o` is 1 in the following cycle.
- R8: The inbound queue holds 16 entries. `rx_ready_o` is 0 exactly when 16 are held. A word is accepted on a cycle with `rx_valid_i` and `rx_ready_o` both 1, and it is stored behind all earlier words.
- R9: A word accepted from the router in the same cycle as a read leaves the inbound occupancy unchanged and keeps the order intact.
- R10: `br_any_rx_o` is 1 exactly when the inbound queue is non-empty, and `br_none_rx_o` is its inverse.
- R11: Operation code 0 does nothing: both queues are unchanged, `res_data_o`=0, and no exception follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Core operation: 0 none, 1 send, 2 peek sender, 3 read word |
| op_node_i | input | 4 | Destination node for a send |
| op_data_i | input | 64 | Word for a send |
| res_data_o | output | 64 | Result of a peek or read |
| exc_o | output | 1 | Illegal operation in the previous cycle |
| br_can_send_o | output | 1 | Outbound queue not full |
| br_send_blocked_o | output | 1 | Outbound queue full |
| br_any_rx_o | output | 1 | Inbound queue not empty |
| br_none_rx_o | output | 1 | Inbound queue empty |
| tx_valid_o | output | 1 | Outbound word available |
| tx_ready_i | input | 1 | Router takes outbound word |
| tx_node_o | output | 4 | Destination of outbound word |
| tx_data_o | output | 64 | Outbound word |
| rx_valid_i | input | 1 | Router offers inbound word |
| rx_ready_o | output | 1 | Inbound queue has space |
| rx_node_i | input | 4 | Sender of inbound word |
| rx_data_i | input | 64 | Inbound word |

## Verification
A wrong occupancy count in either queue shows up in the branch outputs and the ready/valid flags, usually within one cycle of the first miscounted push or pop. A pointer that advances wrongly does not change those flags. Instead, the wrong word appears on `tx_data_o` or `res_data_o` the next time the corrupted slot reaches the head, which can be up to 16 operations later. The bench therefore compares every head value against an independent model on every cycle, and it drives long random runs with the queues near full so that pointer wrap is reached often.

// File: rtl/msg_nif_pkg.sv
package msg_nif_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SEND = 2'd1,
    OP_SRC  = 2'd2,
    OP_RECV = 2'd3
  } nif_op_e;

  // Advance a ring index, wrapping at the queue depth.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // An operation is illegal when the queue it needs cannot serve it.
  function automatic logic op_illegal(input nif_op_e op, input logic tx_full, input logic rx_empty);
    return (op == OP_SEND && tx_full) ||
           ((op == OP_SRC || op == OP_RECV) && rx_empty);
  endfunction

endpackage

// File: rtl/msg_nif_fifo.sv
module msg_nif_fifo
  import msg_nif_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 68
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push_i,
  input  logic [WIDTH-1:0]                din_i,
  input  logic                            pop_i,
  output logic [WIDTH-1:0]                dout_o,
  output logic                            full_o,
  output logic                            empty_o,
  output logic [$clog2(DEPTH+1)-1:0]      count_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CW-1:0]    occ;

  // Named events for the checks below.
  logic push_ok;
  logic pop_ok;

  assign full_o  = (occ == CW'(DEPTH));
  assign empty_o = (occ == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem[rd_ptr];
  assign count_o = occ;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      occ <= CW'(occ_next(int'(occ), push_ok, pop_ok));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R7
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R8
  AST_PTR_MEET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == rd_ptr) |-> (empty_o || full_o)); // R9
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (occ == $past(occ))); // R9

endmodule

// File: rtl/msg_nif_opdec.sv
module msg_nif_opdec
  import msg_nif_pkg::*;
(
  input  nif_op_e op_i,
  input  logic    tx_full_i,
  input  logic    rx_empty_i,
  output logic    tx_push_o,
  output logic    rx_pop_o,
  output logic    sel_src_o,
  output logic    sel_recv_o,
  output logic    illegal_o
);

  always_comb begin
    illegal_o  = op_illegal(op_i, tx_full_i, rx_empty_i);
    tx_push_o  = 1'b0;
    rx_pop_o   = 1'b0;
    sel_src_o  = 1'b0;
    sel_recv_o = 1'b0;
    if (!illegal_o) begin
      unique case (op_i)
        OP_SEND: tx_push_o  = 1'b1;
        OP_SRC:  sel_src_o  = 1'b1;
        OP_RECV: begin
          sel_recv_o = 1'b1;
          rx_pop_o   = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/msg_nif.sv
module msg_nif
  import msg_nif_pkg::*;
#(
  parameter int NODE_W   = 4,
  parameter int DATA_W   = 64,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_i,
  input  logic [NODE_W-1:0] op_node_i,
  input  logic [DATA_W-1:0] op_data_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              exc_o,
  output logic              br_can_send_o,
  output logic              br_send_blocked_o,
  output logic              br_any_rx_o,
  output logic              br_none_rx_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [NODE_W-1:0] tx_node_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [NODE_W-1:0] rx_node_i,
  input  logic [DATA_W-1:0] rx_data_i
);

  localparam int EW  = NODE_W + DATA_W;
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  nif_op_e         op;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            tx_push, tx_pop, rx_push, rx_pop;
  logic            sel_src, sel_recv, illegal;
  logic [EW-1:0]   tx_head, rx_head;
  logic [TCW-1:0]  tx_count;
  logic [RCW-1:0]  rx_count;
  logic            exc_q;

  assign op = nif_op_e'(op_i);

  msg_nif_opdec u_opdec (
    .op_i       (op),
    .tx_full_i  (tx_full),
    .rx_empty_i (rx_empty),
    .tx_push_o  (tx_push),
    .rx_pop_o   (rx_pop),
    .sel_src_o  (sel_src),
    .sel_recv_o (sel_recv),
    .illegal_o  (illegal)
  );

  assign tx_pop  = tx_valid_o && tx_ready_i;
  assign rx_push = rx_valid_i && rx_ready_o;

  msg_nif_fifo #(.DEPTH(TX_DEPTH), .WIDTH(EW)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (tx_push),
    .din_i   ({op_node_i, op_data_i}),
    .pop_i   (tx_pop),
    .dout_o  (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .count_o (tx_count)
  );

  msg_nif_fifo #(.DEPTH(RX_DEPTH), .WIDTH(EW)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_push),
    .din_i   ({rx_node_i, rx_data_i}),
    .pop_i   (rx_pop),
    .dout_o  (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .count_o (rx_count)
  );

  assign tx_valid_o = !tx_empty;
  assign tx_node_o  = tx_head[EW-1 -: NODE_W];
  assign tx_data_o  = tx_head[DATA_W-1:0];
  assign rx_ready_o = !rx_full;

  assign br_can_send_o     = !tx_full;
  assign br_send_blocked_o = tx_full;
  assign br_any_rx_o       = !rx_empty;
  assign br_none_rx_o      = rx_empty;

  always_comb begin
    res_data_o = '0;
    if (sel_src)  res_data_o = DATA_W'(rx_head[EW-1 -: NODE_W]);
    if (sel_recv) res_data_o = rx_head[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= illegal;
  end
  assign exc_o = exc_q;

  AST_EXC_AFTER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> exc_o); // R4
  AST_SEND_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SEND && tx_full && !tx_pop) |=> (tx_count == $past(tx_count))); // R4
  AST_SRC_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SRC && !rx_push) |=> (rx_count == $past(rx_count))); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_SRC || op == OP_RECV) && rx_empty) |-> (res_data_o == '0)); // R7
  AST_RX_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == RCW'(RX_DEPTH)) |-> !rx_ready_o); // R8
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> !exc_o); // R11

endmodule

// File: tb/msg_nif_tb_top.sv
module msg_nif_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  op_node_i = '0;
  logic [63:0] op_data_i = '0;
  logic [63:0] res_data_o;
  logic        exc_o, br_can_send_o, br_send_blocked_o, br_any_rx_o, br_none_rx_o;
  logic        tx_valid_o, tx_ready_i = 1'b0;
  logic [3:0]  tx_node_o;
  logic [63:0] tx_data_o;
  logic        rx_valid_i = 1'b0, rx_ready_o;
  logic [3:0]  rx_node_i = '0;
  logic [63:0] rx_data_i = '0;

  always #4 clk = ~clk;

  msg_nif dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .op_node_i(op_node_i), .op_data_i(op_data_i),
    .res_data_o(res_data_o), .exc_o(exc_o), .br_can_send_o(br_can_send_o),
    .br_send_blocked_o(br_send_blocked_o), .br_any_rx_o(br_any_rx_o), .br_none_rx_o(br_none_rx_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_node_o(tx_node_o), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_node_i(rx_node_i), .rx_data_i(rx_data_i)
  );

  int checks = 0;
  int errors = 0;

  // Bench model: ring buffers of {node, data}.
  logic [67:0] txm [8];
  logic [67:0] rxm [16];
  int tx_h = 0, tx_n = 0, rx_h = 0, rx_n = 0;
  logic exc_exp = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_result(input logic [1:0] op);
    if (op == 2'd2 && rx_n > 0) return 64'(rxm[rx_h][67:64]);
    if (op == 2'd3 && rx_n > 0) return rxm[rx_h][63:0];
    return 64'd0;
  endfunction

  // One cycle: drive, check outputs before the edge, advance the model.
  task automatic step(input logic [1:0] op, input logic [3:0] nd, input logic [63:0] dt,
                      input logic rv, input logic [3:0] rn, input logic [63:0] rd, input logic tr);
    logic [63:0] er;
    bit tx_fire, send_ok, rx_acc, recv_ok;
    @(negedge clk);
    op_i = op; op_node_i = nd; op_data_i = dt;
    rx_valid_i = rv; rx_node_i = rn; rx_data_i = rd; tx_ready_i = tr;
    #1;
    chk(exc_o == exc_exp, "R4 R7 exc", 68'(exc_o), 68'(exc_exp));
    chk(tx_valid_o == (tx_n > 0), "R2 tx_valid", 68'(tx_valid_o), 68'(tx_n > 0));
    if (tx_n > 0)
      chk({tx_node_o, tx_data_o} == txm[tx_h], "R2 tx head", {tx_node_o, tx_data_o}, txm[tx_h]);
    chk(br_can_send_o == (tx_n < 8) && br_send_blocked_o == (tx_n == 8), "R3 send status",
        68'({br_can_send_o, br_send_blocked_o}), 68'({tx_n < 8, tx_n == 8}));
    chk(br_any_rx_o == (rx_n > 0) && br_none_rx_o == (rx_n == 0), "R10 rx status",
        68'({br_any_rx_o, br_none_rx_o}), 68'({rx_n > 0, rx_n == 0}));
    chk(rx_ready_o == (rx_n < 16), "R8 rx_ready", 68'(rx_ready_o), 68'(rx_n < 16));
    er = exp_result(op);
    chk(res_data_o == er, (op == 2'd2) ? "R5 peek" : (op == 2'd3) ? "R6 read" : "R11 idle result",
        68'(res_data_o), 68'(er));
    tx_fire = (tx_n > 0) && tr;
    send_ok = (op == 2'd1) && (tx_n < 8);
    rx_acc  = rv && (rx_n < 16);
    recv_ok = (op == 2'd3) && (rx_n > 0);
    exc_exp = ((op == 2'd1) && tx_n == 8) || ((op == 2'd2 || op == 2'd3) && rx_n == 0);
    if (tx_fire) begin tx_h = (tx_h + 1) % 8; tx_n--; end
    if (send_ok) begin txm[(tx_h + tx_n) % 8] = {nd, dt}; tx_n++; end
    if (recv_ok) begin rx_h = (rx_h + 1) % 16; rx_n--; end
    if (rx_acc)  begin rxm[(rx_h + rx_n) % 16] = {rn, rd}; rx_n++; end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!tx_valid_o && rx_ready_o && br_none_rx_o && br_can_send_o && !exc_o, "R1 reset",
        68'({tx_valid_o, rx_ready_o, br_none_rx_o, br_can_send_o, exc_o}), 68'(5'b01110));
    rst_n = 1'b1;
    // R3 R4: fill outbound queue then overflow
    for (int i = 0; i < 9; i++) step(2'd1, 4'(i), 64'hA000 + 64'(i), 0, 0, 0, 0);
    step(2'd0, 0, 0, 0, 0, 0, 0); // R4 exception seen, R11 idle quiet next
    // R2 order while draining
    for (int i = 0; i < 10; i++) step(2'd0, 0, 0, 0, 0, 0, 1);
    // R7 empty peek/read
    step(2'd2, 0, 0, 0, 0, 0, 0);
    step(2'd3, 0, 0, 0, 0, 0, 0);
    // R8 fill inbound to 17 offers
    for (int i = 0; i < 17; i++) step(2'd0, 0, 0, 1, 4'(15 - i), 64'hB000 + 64'(i), 0);
    step(2'd2, 0, 0, 0, 0, 0, 0);  // R5 peek keeps head
    step(2'd2, 0, 0, 0, 0, 0, 0);
    // R9 read with simultaneous arrival (full case and normal case)
    for (int i = 0; i < 4; i++) step(2'd3, 0, 0, 1, 4'(i), 64'hC000 + 64'(i), 0);
    for (int i = 0; i < 20; i++) step(2'd3, 0, 0, 0, 0, 0, 0); // R6 drain
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] rop;
      rop = 2'($urandom_range(0, 3));
      step(rop, 4'($urandom), {$urandom, $urandom}, 1'($urandom_range(0, 2) != 0),
           4'($urandom), {$urandom, $urandom}, 1'($urandom_range(0, 3) == 0));
    end
    step(2'd0, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule